// File: doc/BRIEF.md
# Nibble-Mapped Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 4-bit processor core. Ten request sources feed it with one-cycle event pulses. Four of them are timers, one is an external interrupt pin, one is a serial port, one is a comparator, and three are port pins. Each source has its own pending flag. Each flag is set by its pulse whether or not the source is enabled.

Software uses a simple address/data bus with 4-bit registers. Through it, software sets one enable bit per source and a single global enable. A request goes to the core when all three of these are true for at least one source: the global enable, the source enable and the pending flag. The controller then presents the index of the highest-priority source that qualifies.

When the core acknowledges, three things happen:
- the pending flag of the serviced source is cleared;
- the global enable drops, which blocks further interrupts;
- the global enable stays low until software writes it back to 1 or the core signals a return from interrupt.

Pending flags are otherwise removed only by an 8-bit clear mask. In that mask, the three port-pin flags share one bit.

Top module: `nibint_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is 0.
- R2: Register map:
  - address 0x39 holds the timer enables, with bit n for timer n (n = 0..3);
  - address 0x3A holds bit 2 = external pin, bit 1 = serial, bit 0 = comparator;
  - address 0x3B holds bit 2 = port pin 0, bit 1 = port pin 1, bit 0 = port pin 2;
  - address 0x34 holds the global enable in bit 0.
  Reserved bits read 0. Any other address reads 0, and writes to it change nothing.
- R3: `irq_req` is 1 exactly when some source has global enable, source enable and pending flag all set.
- R4: A 1 on `src_evt[i]` sets pending flag i even if source i is disabled. The index order is:
  - 0 to 3: timers 0 to 3;
  - 4: external pin;
  - 5: serial;
  - 6: comparator;
  - 7 to 9: port pins 0 to 2.
- R5: A take is `ack` high while `irq_req` is high. A take clears the global enable at that clock edge, so `irq_req` is 0 in the next cycle. `ack` without `irq_req` has no effect.
- R6: A take clears only the pending flag of the index shown on `irq_idx`. All other flags keep their state.
- R7: The global enable is set again by writing 1 to bit 0 of 0x34, or by a `reti` pulse. Writing 0 to that bit clears it.
- R8: With `clr_valid` high, each 1 in `clr_mask` clears flags as follows:
  - bits 0..3 clear timers 0..3;
  - bit 4 clears the external pin;
  - bit 5 clears the serial port;
  - bit 6 clears the comparator;
  - bit 7 clears all three port-pin flags.
- R9: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R10: Priority is fixed, with the lowest index highest. `irq_idx` gives the 4-bit index (0..9) of the winning source.
- R11: Within one cycle, a take overrides both a bus write to 0x34 and `reti`, and leaves the global enable at 0. A bus write to 0x34 overrides `reti`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address, also used for reads |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr` (combinational) |
| src_evt | input | 10 | One-cycle event pulses, one per source |
| clr_valid | input | 1 | Apply `clr_mask` this cycle |
| clr_mask | input | 8 | Pending-flag clear mask |
| ack | input | 1 | Core takes the presented request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_idx | output | 4 | Index of the winning source |

## Verification
The bench builds the block with its default parameters:
- the 8-bit address bus;
- the register addresses 0x34, 0x39, 0x3A and 0x3B;
- the loop-based priority encoder (`ARB_IMPL` = 0).

With every source pending and enabled, repeated take and return cycles walk `irq_idx` through all ten priorities. Each step shows that a take removes only its own flag. The clear-mask sweep relies on the shared port-pin bit, and the same-cycle collisions of take, return and bus write test the precedence of the global enable. Building with `ARB_IMPL` = 1 instead would exercise the lowest-set-bit encoder against the same expectations.

// File: rtl/nibint_pkg.sv
package nibint_pkg;
   localparam int NUM_SRC = 10;
   localparam int IDX_W   = 4;
   localparam int MASK_W  = 8;
   localparam int DATA_W  = 4;
   localparam int NUM_PIN = 3;

   typedef logic [NUM_SRC-1:0] src_vec_t;

   // spread the 8-bit clear mask over the ten pending flags
   function automatic src_vec_t expand_clear(input logic [MASK_W-1:0] m);
      src_vec_t v;
      v = '0;
      for (int i = 0; i < MASK_W - 1; i++) v[i] = m[i];
      for (int p = 0; p < NUM_PIN; p++) v[MASK_W-1+p] = m[MASK_W-1];
      return v;
   endfunction
endpackage

// File: rtl/nibint_regs.sv
module nibint_regs
   import nibint_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter logic [7:0]  ADDR_GIE    = 8'h34,
   parameter logic [7:0]  ADDR_EN_TMR = 8'h39,
   parameter logic [7:0]  ADDR_EN_A   = 8'h3A,
   parameter logic [7:0]  ADDR_EN_B   = 8'h3B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              take,
   input  logic              reti,
   output logic              gie,
   output src_vec_t          en_vec
);
   localparam int NUM_TMR = NUM_SRC - 6;

   logic [NUM_TMR-1:0] en_tmr_q;
   logic [2:0]         en_a_q;
   logic [2:0]         en_b_q;
   logic               gie_q;

   logic hit_gie, hit_tmr, hit_a, hit_b;

   always_comb begin
      hit_gie = (addr == ADDR_W'(ADDR_GIE));
      hit_tmr = (addr == ADDR_W'(ADDR_EN_TMR));
      hit_a   = (addr == ADDR_W'(ADDR_EN_A));
      hit_b   = (addr == ADDR_W'(ADDR_EN_B));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_tmr_q <= '0;
         en_a_q   <= '0;
         en_b_q   <= '0;
      end else if (wr) begin
         if (hit_tmr) en_tmr_q <= wdata[NUM_TMR-1:0];
         if (hit_a)   en_a_q   <= wdata[2:0];
         if (hit_b)   en_b_q   <= wdata[2:0];
      end
   end

   // a take beats a write, a write beats the return strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gie_q <= 1'b0;
      else if (take)           gie_q <= 1'b0;
      else if (wr && hit_gie)  gie_q <= wdata[0];
      else if (reti)           gie_q <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      if (hit_gie)      rdata = {{(DATA_W-1){1'b0}}, gie_q};
      else if (hit_tmr) rdata = DATA_W'(en_tmr_q);
      else if (hit_a)   rdata = {1'b0, en_a_q};
      else if (hit_b)   rdata = {1'b0, en_b_q};
   end

   always_comb begin
      en_vec = '0;
      en_vec[NUM_TMR-1:0] = en_tmr_q;
      for (int k = 0; k < 3; k++) begin
         en_vec[NUM_TMR+k]   = en_a_q[2-k];
         en_vec[NUM_TMR+3+k] = en_b_q[2-k];
      end
   end

   assign gie = gie_q;

   // R7: a return strobe alone raises the global enable
   a_r7_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !take && !(wr && hit_gie)) |=> gie_q);

   // R11: a take always leaves the global enable low
   a_r11_take_wins: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !gie_q);
endmodule

// File: rtl/nibint_pending.sv
module nibint_pending
   import nibint_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  src_vec_t         evt,
   input  src_vec_t         clr_vec,
   input  logic             take,
   input  logic [IDX_W-1:0] take_idx,
   output src_vec_t         pend
);
   src_vec_t pend_q;
   src_vec_t ack_vec;

   always_comb begin
      ack_vec = '0;
      if (take) ack_vec[take_idx] = 1'b1;
   end

   // a new event overrides any clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec & ~ack_vec) | evt;
   end

   assign pend = pend_q;

   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_flag_chk
         // R9 and R4: an event always leaves its flag set
         a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> pend_q[g]);
      end
   endgenerate

   // R6: exactly one flag is dropped by an undisturbed take
   a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (take && clr_vec == '0 && evt == '0)
      |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/nibint_arbiter.sv
module nibint_arbiter
   import nibint_pkg::*;
#(
   parameter int ARB_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_vec_t         active,
   output logic             req,
   output logic [IDX_W-1:0] idx
);
   assign req = |active;

   generate
      if (ARB_IMPL == 0) begin : g_loop
         always_comb begin
            idx = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--)
               if (active[i]) idx = IDX_W'(i);
         end
      end else begin : g_onehot
         src_vec_t grant;
         always_comb begin
            grant = active & (~active + src_vec_t'(1));
            idx   = '0;
            for (int i = 0; i < NUM_SRC; i++)
               if (grant[i]) idx = idx | IDX_W'(i);
         end
      end
   endgenerate

   // R10: nothing of higher priority is active than the winner
   a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (active[idx] &&
               ((active & ((src_vec_t'(1) << idx) - src_vec_t'(1))) == '0)));
endmodule

// File: rtl/nibint_ctrl.sv
module nibint_ctrl
   import nibint_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter logic [7:0]  ADDR_GIE    = 8'h34,
   parameter logic [7:0]  ADDR_EN_TMR = 8'h39,
   parameter logic [7:0]  ADDR_EN_A   = 8'h3A,
   parameter logic [7:0]  ADDR_EN_B   = 8'h3B,
   parameter int          ARB_IMPL    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [3:0]        bus_wdata,
   output logic [3:0]        bus_rdata,
   input  logic [9:0]        src_evt,
   input  logic              clr_valid,
   input  logic [7:0]        clr_mask,
   input  logic              ack,
   input  logic              reti,
   output logic              irq_req,
   output logic [3:0]        irq_idx
);
   generate
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_width
         $error("nibint_ctrl: ADDR_W must lie in 6..8");
      end
      if (ADDR_GIE == ADDR_EN_TMR || ADDR_GIE == ADDR_EN_A || ADDR_GIE == ADDR_EN_B ||
          ADDR_EN_TMR == ADDR_EN_A || ADDR_EN_TMR == ADDR_EN_B || ADDR_EN_A == ADDR_EN_B)
      begin : g_bad_map
         $error("nibint_ctrl: register addresses must be distinct");
      end
      if (ARB_IMPL != 0 && ARB_IMPL != 1) begin : g_bad_arb
         $error("nibint_ctrl: ARB_IMPL must be 0 or 1");
      end
   endgenerate

   logic     gie;
   src_vec_t en_vec;
   src_vec_t pend;
   src_vec_t active;
   src_vec_t clr_vec;
   logic     take;

   assign take    = ack & irq_req;
   assign clr_vec = clr_valid ? expand_clear(clr_mask) : '0;
   assign active  = pend & en_vec & {NUM_SRC{gie}};

   nibint_regs #(
      .ADDR_W(ADDR_W), .ADDR_GIE(ADDR_GIE), .ADDR_EN_TMR(ADDR_EN_TMR),
      .ADDR_EN_A(ADDR_EN_A), .ADDR_EN_B(ADDR_EN_B)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .rdata(bus_rdata), .take(take), .reti(reti), .gie(gie), .en_vec(en_vec)
   );

   nibint_pending i_pend (
      .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr_vec(clr_vec),
      .take(take), .take_idx(irq_idx), .pend(pend)
   );

   nibint_arbiter #(.ARB_IMPL(ARB_IMPL)) i_arb (
      .clk(clk), .rst_n(rst_n), .active(active), .req(irq_req), .idx(irq_idx)
   );

   // R5: the request line falls right after a take
   a_r5_take_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !irq_req);

   // R3: a raised request is backed by all three conditions
   a_r3_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (gie && en_vec[irq_idx] && pend[irq_idx]));

   // R8: a port-pin clear without events empties all three pin flags
   a_r8_pin_group: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && clr_mask[7] && src_evt[9:7] == 3'b000) |=> (pend[9:7] == 3'b000));
endmodule

// File: tb/test_nibint_ctrl.sv
module test_nibint_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_wdata = '0;
   logic [3:0] bus_rdata;
   logic [9:0] src_evt = '0;
   logic       clr_valid = 1'b0;
   logic [7:0] clr_mask = '0;
   logic       ack = 1'b0;
   logic       reti = 1'b0;
   logic       irq_req;
   logic [3:0] irq_idx;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibint_ctrl i_nibint_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
      .clr_valid(clr_valid), .clr_mask(clr_mask), .ack(ack), .reti(reti),
      .irq_req(irq_req), .irq_idx(irq_idx)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick;
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
      bus_addr = a;
      #1;
      chk(req, int'(bus_rdata), exp);
   endtask

   task automatic pulse_evt(input logic [9:0] v);
      src_evt = v; tick; src_evt = '0;
   endtask

   task automatic clr(input logic [7:0] m);
      clr_valid = 1'b1; clr_mask = m; tick; clr_valid = 1'b0; clr_mask = '0;
   endtask

   task automatic do_ack;
      ack = 1'b1; tick; ack = 1'b0;
   endtask

   task automatic do_reti;
      reti = 1'b1; tick; reti = 1'b0;
   endtask

   task automatic req_chk(input string req, input int exp_req, input int exp_idx);
      chk(req, int'(irq_req), exp_req);
      if (exp_req != 0) chk(req, int'(irq_idx), exp_idx);
   endtask

   task automatic enable_all;
      wr(8'h39, 4'hF); wr(8'h3A, 4'h7); wr(8'h3B, 4'h7); wr(8'h34, 4'h1);
   endtask

   task automatic wipe;
      clr(8'hFF);
      wr(8'h39, 4'h0); wr(8'h3A, 4'h0); wr(8'h3B, 4'h0); wr(8'h34, 4'h0);
   endtask

   task automatic t_reset;
      rd_chk("R1", 8'h34, 0); rd_chk("R1", 8'h39, 0);
      rd_chk("R1", 8'h3A, 0); rd_chk("R1", 8'h3B, 0);
      chk("R1", int'(irq_req), 0);
   endtask

   task automatic t_regs;
      wr(8'h39, 4'hF); rd_chk("R2", 8'h39, 15);
      wr(8'h3A, 4'hF); rd_chk("R2", 8'h3A, 7);
      wr(8'h3B, 4'hD); rd_chk("R2", 8'h3B, 5);
      wr(8'h34, 4'hF); rd_chk("R2", 8'h34, 1);
      wr(8'h20, 4'h0); rd_chk("R2", 8'h20, 0);
      rd_chk("R2", 8'h39, 15); rd_chk("R2", 8'h3B, 5); rd_chk("R2", 8'h34, 1);
      wipe;
   endtask

   task automatic t_pend_disabled;
      wr(8'h34, 4'h1);
      pulse_evt(10'h3FF);
      req_chk("R4", 0, 0);
      wr(8'h3B, 4'h1);           // port pin 2 only
      req_chk("R3", 1, 9);
      wr(8'h3A, 4'h1);           // comparator
      req_chk("R3", 1, 6);
      wr(8'h34, 4'h0);
      req_chk("R3", 0, 0);
      wr(8'h34, 4'h1);
      req_chk("R7", 1, 6);
      wipe;
   endtask

   task automatic t_priority_walk;
      pulse_evt(10'h3FF);
      enable_all;
      for (int k = 0; k < 10; k++) begin
         req_chk("R10", 1, k);
         do_ack;
         req_chk("R5", 0, 0);
         rd_chk("R5", 8'h34, 0);
         do_reti;
         rd_chk("R7", 8'h34, 1);
      end
      req_chk("R6", 0, 0);
      wipe;
   endtask

   task automatic t_clear_mask;
      pulse_evt(10'h3FF);
      enable_all;
      clr(8'h0F); req_chk("R8", 1, 4);
      clr(8'h10); req_chk("R8", 1, 5);
      clr(8'h20); req_chk("R8", 1, 6);
      clr(8'h40); req_chk("R8", 1, 7);
      clr(8'h80); req_chk("R8", 0, 0);
      wipe;
   endtask

   task automatic t_set_wins;
      wr(8'h39, 4'hF); wr(8'h34, 4'h1);
      src_evt = 10'h004; clr_valid = 1'b1; clr_mask = 8'h04;
      tick;
      src_evt = '0; clr_valid = 1'b0; clr_mask = '0;
      req_chk("R9", 1, 2);
      clr(8'h04);
      req_chk("R9", 0, 0);
      wipe;
   endtask

   task automatic t_ack_collisions;
      wr(8'h39, 4'hF); wr(8'h34, 4'h1);
      // ack without request changes nothing
      do_ack;
      rd_chk("R5", 8'h34, 1);
      pulse_evt(10'h001);
      req_chk("R11", 1, 0);
      ack = 1'b1; reti = 1'b1; tick; ack = 1'b0; reti = 1'b0;
      rd_chk("R11", 8'h34, 0);
      wr(8'h34, 4'h1);
      pulse_evt(10'h002);
      req_chk("R11", 1, 1);
      ack = 1'b1; bus_addr = 8'h34; bus_wdata = 4'h1; bus_wr = 1'b1;
      tick;
      ack = 1'b0; bus_wr = 1'b0;
      rd_chk("R11", 8'h34, 0);
      wr(8'h34, 4'h1);
      req_chk("R6", 0, 0);
      // write of 0 overrides the return strobe
      reti = 1'b1; bus_addr = 8'h34; bus_wdata = 4'h0; bus_wr = 1'b1;
      tick;
      reti = 1'b0; bus_wr = 1'b0;
      rd_chk("R11", 8'h34, 0);
      wipe;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick; tick;
      rst_n = 1'b1;
      tick;
      t_reset;
      t_regs;
      t_pend_disabled;
      t_priority_walk;
      t_clear_mask;
      t_set_wins;
      t_ack_collisions;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule